// File: doc/BRIEF.md
# Seconds-minutes-hours real-time clock

This block keeps time of day as seconds, minutes and hours. Its timebase is a free-running binary counter that advances on each pulse of a 32.768 kHz clock enable. With its default width of 16 bits, a counter started at zero overflows only after two seconds.

To get a one-second period, the counter is not reloaded with a full preset value at each overflow. Instead, only its most significant bit is set, and the lower bits keep counting from zero. Because the low bits are never rewritten, no error builds up from one second to the next.

Each overflow is a one-second tick. When the interrupt enable is set, the tick advances the seconds field and produces a single-cycle interrupt pulse. The carry runs on from seconds to minutes and from minutes to hours. Software can preset the time through a load strobe, and a synchronous clear returns everything to zero.

Top module: `rtc_hms`

## Requirements
- R1: An active-low asynchronous reset (`rst_ni` = 0) or a synchronous clear (`clr_i` = 1 at a clock edge) sets the timebase counter, seconds, minutes and hours to 0 and holds `irq_o` low.
- R2: The timebase counter advances by one only on clock edges where `tick_en_i` = 1. Starting from zero, its first overflow happens on the 2^CNT_W-th enabled edge (65536 enables, two seconds, with CNT_W = 16).
- R3: On overflow, the counter is reloaded with only its top bit set and all lower bits zero. Every later overflow therefore comes exactly 2^(CNT_W-1) enables after the previous one (32768 enables, one second).
- R4: When `irq_en_i` = 1 on an overflow edge, seconds increments by one on that edge. `irq_o` is high for exactly the one cycle that follows that edge, which is the cycle in which the new seconds value first appears.
- R5: When `irq_en_i` = 0 on an overflow edge, the counter still reloads and keeps running, but seconds, minutes and hours do not change and `irq_o` stays low.
- R6: Seconds counts 0 to 59 and wraps to 0, and each wrap increments minutes. Minutes counts 0 to 59 and wraps to 0, and each wrap increments hours. Hours counts 0 to 23 and wraps to 0. All three fields update on the same edge.
- R7: `load_i` = 1 at a clock edge writes `load_sec_i`, `load_min_i` and `load_hr_i` into the fields. A value above its field's maximum is stored as that maximum: 59 for seconds, 59 for minutes, 23 for hours.
- R8: Priority is clear, then load, then tick. A load on an overflow edge stores the loaded values and raises no interrupt. A load never changes the timebase counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of counter and time |
| tick_en_i | input | 1 | 32.768 kHz count enable, one cycle per pulse |
| irq_en_i | input | 1 | Enables seconds update and interrupt on overflow |
| load_i | input | 1 | Preset strobe for the time fields |
| load_sec_i | input | 6 | Seconds value to load |
| load_min_i | input | 6 | Minutes value to load |
| load_hr_i | input | 5 | Hours value to load |
| sec_o | output | 6 | Seconds, 0 to 59 |
| min_o | output | 6 | Minutes, 0 to 59 |
| hr_o | output | 5 | Hours, 0 to 23 |
| irq_o | output | 1 | One-cycle one-second interrupt pulse |

## Verification
The hardest situations to reach are a load that lands exactly on an overflow edge and an overflow that is suppressed while the timebase keeps its phase. Neither is visible directly at the ports.

To reach them, the bench builds the design with a narrow counter. It stops `tick_en_i` while it clears and loads, so that the counter phase is known. It then counts enabled edges up to the overflow before striking `load_i` or dropping `irq_en_i`.

The phase after a suppressed or overridden tick is shown by the exact edge on which the next tick lands. The full 23:59:59 rollover and the clamping of loaded values are reached by loading the time directly.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int SEC_LAST = 59;
  localparam int MIN_LAST = 59;
  localparam int HR_LAST  = 23;
  localparam int SEC_W    = $clog2(SEC_LAST + 1);
  localparam int MIN_W    = $clog2(MIN_LAST + 1);
  localparam int HR_W     = $clog2(HR_LAST + 1);
endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int CNT_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic ovf_o
);
  localparam logic [CNT_W-1:0] RELOAD = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] cnt_q;

  assign ovf_o = en_i & ~clr_i & (&cnt_q);

  // only the top bit is forced on wrap; low bits roll through zero untouched
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (ovf_o)     cnt_q <= RELOAD;
    else if (en_i)      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_field.sv
module rtc_field #(
  parameter int W    = 6,
  parameter int LAST = 59
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] val_o
);
  localparam logic [W-1:0] LAST_V = W'(LAST);

  logic [W-1:0] val_q;
  logic [W-1:0] load_clamped;

  assign load_clamped = (load_val_i > LAST_V) ? LAST_V : load_val_i;
  assign val_o        = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      val_q <= '0;
    else if (clr_i)   val_q <= '0;
    else if (load_i)  val_q <= load_clamped;
    else if (inc_i)   val_q <= (val_q == LAST_V) ? '0 : val_q + 1'b1;
  end
endmodule

// File: rtl/rtc_hms.sv
module rtc_hms
  import rtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_en_i,
  input  logic             irq_en_i,
  input  logic             load_i,
  input  logic [SEC_W-1:0] load_sec_i,
  input  logic [MIN_W-1:0] load_min_i,
  input  logic [HR_W-1:0]  load_hr_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [MIN_W-1:0] min_o,
  output logic [HR_W-1:0]  hr_o,
  output logic             irq_o
);
  logic ovf;
  logic step;
  logic sec_wrap;
  logic min_wrap;
  logic irq_q;

  rtc_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .en_i   (tick_en_i),
    .ovf_o  (ovf)
  );

  // load and clear override the tick; the timebase is untouched by load
  assign step     = ovf & irq_en_i & ~load_i & ~clr_i;
  assign sec_wrap = step & (sec_o == SEC_W'(SEC_LAST));
  assign min_wrap = sec_wrap & (min_o == MIN_W'(MIN_LAST));

  rtc_field #(.W(SEC_W), .LAST(SEC_LAST)) u_sec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .load_i     (load_i),
    .load_val_i (load_sec_i),
    .inc_i      (step),
    .val_o      (sec_o)
  );

  rtc_field #(.W(MIN_W), .LAST(MIN_LAST)) u_min (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .load_i     (load_i),
    .load_val_i (load_min_i),
    .inc_i      (sec_wrap),
    .val_o      (min_o)
  );

  rtc_field #(.W(HR_W), .LAST(HR_LAST)) u_hr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .load_i     (load_i),
    .load_val_i (load_hr_i),
    .inc_i      (min_wrap),
    .val_o      (hr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= step;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/rtc_hms_chk.sv
module rtc_hms_chk
  import rtc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             irq_en_i,
  input logic             load_i,
  input logic [SEC_W-1:0] sec_o,
  input logic [MIN_W-1:0] min_o,
  input logic [HR_W-1:0]  hr_o,
  input logic             irq_o
);
  p_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> (sec_o == '0 && min_o == '0 && hr_o == '0 && !irq_o));

  p_irq_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_sec_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sec_o) && $past(!load_i && !clr_i)) |-> irq_o);

  p_irq_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(irq_en_i && !load_i && !clr_i));

  p_fields_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_o <= SEC_W'(SEC_LAST) && min_o <= MIN_W'(MIN_LAST) && hr_o <= HR_W'(HR_LAST));

  p_min_carry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(min_o) && $past(!load_i && !clr_i)) |->
      (sec_o == '0 && $past(sec_o) == SEC_W'(SEC_LAST)));
endmodule

bind rtc_hms rtc_hms_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clr_i    (clr_i),
  .irq_en_i (irq_en_i),
  .load_i   (load_i),
  .sec_o    (sec_o),
  .min_o    (min_o),
  .hr_o     (hr_o),
  .irq_o    (irq_o)
);

// File: tb/rtc_hms_tb.sv
module rtc_hms_tb;
  localparam int CW   = 8;
  localparam int FULL = 1 << CW;
  localparam int HALF = 1 << (CW - 1);

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clr_i = 1'b0;
  logic       tick_en_i = 1'b0;
  logic       irq_en_i = 1'b0;
  logic       load_i = 1'b0;
  logic [5:0] load_sec_i = '0;
  logic [5:0] load_min_i = '0;
  logic [4:0] load_hr_i = '0;
  logic [5:0] sec_o;
  logic [5:0] min_o;
  logic [4:0] hr_o;
  logic       irq_o;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  rtc_hms #(.CNT_W(CW)) u_dut (
    .clk_i, .rst_ni, .clr_i, .tick_en_i, .irq_en_i, .load_i,
    .load_sec_i, .load_min_i, .load_hr_i,
    .sec_o, .min_o, .hr_o, .irq_o
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_time(input string req, input int s, input int m, input int h, input int irq);
    check(req, "sec", int'(sec_o), s);
    check(req, "min", int'(min_o), m);
    check(req, "hr", int'(hr_o), h);
    check(req, "irq", int'(irq_o), irq);
  endtask

  task automatic setup(input int s, input int m, input int h);
    tick_en_i = 1'b0;
    clr_i = 1'b1;
    step(1);
    clr_i = 1'b0;
    load_i = 1'b1;
    load_sec_i = 6'(s);
    load_min_i = 6'(m);
    load_hr_i = 5'(h);
    step(1);
    load_i = 1'b0;
  endtask

  task automatic t_reset;
    check_time("R1", 0, 0, 0, 0);
  endtask

  // R2 first overflow after FULL enables, R3 then every HALF, R4 pulse
  task automatic t_first_ticks;
    irq_en_i = 1'b1;
    tick_en_i = 1'b1;
    step(FULL - 1);
    check_time("R2", 0, 0, 0, 0);
    step(1);
    check_time("R4", 1, 0, 0, 1);
    step(1);
    check("R4", "irq drop", int'(irq_o), 0);
    step(HALF - 2);
    check_time("R3", 1, 0, 0, 0);
    step(1);
    check_time("R3", 2, 0, 0, 1);
  endtask

  // R5 suppressed overflow keeps the counter phase
  task automatic t_irq_off;
    irq_en_i = 1'b0;
    for (int i = 0; i < HALF; i++) begin
      step(1);
      if (irq_o !== 1'b0) check("R5", "irq while disabled", int'(irq_o), 0);
    end
    check_time("R5", 2, 0, 0, 0);
    irq_en_i = 1'b1;
    step(HALF - 1);
    check_time("R5", 2, 0, 0, 0);
    step(1);
    check_time("R3", 3, 0, 0, 1);
  endtask

  task automatic t_clamp_clear;
    setup(60, 63, 24);
    check_time("R7", 59, 59, 23, 0);
    setup(45, 12, 7);
    check_time("R7", 45, 12, 7, 0);
    clr_i = 1'b1;
    step(1);
    clr_i = 1'b0;
    check_time("R1", 0, 0, 0, 0);
  endtask

  task automatic t_roll(input int s, input int m, input int h,
                        input int es, input int em, input int eh);
    setup(s, m, h);
    check_time("R7", s, m, h, 0);
    tick_en_i = 1'b1;
    step(FULL - 1);
    check_time("R6", s, m, h, 0);
    step(1);
    check_time("R6", es, em, eh, 1);
    tick_en_i = 1'b0;
  endtask

  // R8 load on the overflow edge wins, counter phase unchanged; clear beats load
  task automatic t_priority;
    setup(0, 0, 0);
    tick_en_i = 1'b1;
    step(FULL - 1);
    load_i = 1'b1;
    load_sec_i = 6'd30;
    load_min_i = 6'd20;
    load_hr_i = 5'd10;
    step(1);
    load_i = 1'b0;
    check_time("R8", 30, 20, 10, 0);
    step(HALF - 1);
    check_time("R8", 30, 20, 10, 0);
    step(1);
    check_time("R8", 31, 20, 10, 1);
    tick_en_i = 1'b0;
    clr_i = 1'b1;
    load_i = 1'b1;
    load_sec_i = 6'd5;
    step(1);
    clr_i = 1'b0;
    load_i = 1'b0;
    check_time("R8", 0, 0, 0, 0);
  endtask

  initial begin
    step(2);
    rst_ni = 1'b1;
    step(1);
    t_reset();
    t_first_ticks();
    t_irq_off();
    t_clamp_clear();
    t_roll(10, 5, 1, 11, 5, 1);
    t_roll(59, 30, 12, 0, 31, 12);
    t_roll(59, 59, 3, 0, 0, 4);
    t_roll(59, 59, 23, 0, 0, 0);
    t_priority();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule